// File: doc/BRIEF.md
# Half-Table Constant Multiplier

This block multiplies a 4-bit unsigned operand by a coefficient fixed at elaboration time. It does not keep a sixteen-entry product table. Its table holds eight words, which are the coefficient times 1, 3, 5 and so on up to 15. Any other operand is split into an odd factor and a power of two. The odd factor picks a table word, and the power of two drives a two-stage logarithmic left shifter. An operand of zero gives no table read at all: a row of NOR gates clears the product.

The design is a two-register pipeline. The first register holds the table word, the shift amount and the clear flag. The second register holds the finished product, which is W+4 bits wide. A product appears two clock edges after its operand is accepted. The output register keeps its value until the next accepted operand reaches it. The block suits constant-coefficient taps in filters, where the coefficient never changes while the chip runs.

Top module: `odd_lut_mult`

## Requirements
- R1: For every operand X in 0 to 15, with `in_valid` high, `product` equals COEF·X as an unsigned (W+4)-bit value.
- R2: `out_valid` is high exactly two rising edges after the edge that accepted an operand with `in_valid` high, and is low otherwise.
- R3: An operand of 0 gives a product of 0, even when the coefficient is nonzero.
- R4: The control logic writes each nonzero X as m·2^s, with m odd and s between 0 and 3. It selects table word (m−1)/2 and shifts that word left by s. Even operands therefore match the product exactly. For example, X = 8 uses the 1·COEF word shifted by 3, and X = 12 uses the 3·COEF word shifted by 2.
- R5: While no operand is accepted, `product` keeps its last value.
- R6: While `rst_n` is low, and on the first sample after it is released, `out_valid` is 0 and `product` is 0.
- R7: A coefficient of 0 gives 0 for every operand. The largest W-bit coefficient (2^W−1) times 15 is returned with no loss of high bits.
- R8: When COEF is nonzero, every nonzero operand gives a nonzero product.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | The operand is accepted on this edge |
| x | input | 4 | Unsigned operand |
| out_valid | output | 1 | `product` holds a new result |
| product | output | W+4 | COEF·X |

## Verification
The case hardest to reach is the one where the two largest factors meet: the largest coefficient with X = 15, and X = 8 shifted by three from the smallest table word. These sit in the top bits of the product, where a shifter or a table that is too narrow would drop bits. The bench builds four copies of the block with coefficients 0, 1, 181 and the all-ones value. It drives all sixteen operands back to back, then again in a scrambled order with idle gaps. This order puts a clear right after a full-width product and an odd operand right after an even one, so a leftover shift or a sticky clear would show.

// File: rtl/odd_lut_mult_pkg.sv
package odd_lut_mult_pkg;
    localparam int unsigned IN_W   = 4;
    localparam int unsigned ADDR_W = IN_W - 1;
    localparam int unsigned SH_W   = 2;
    localparam int unsigned DEPTH  = 1 << ADDR_W;
endpackage

// File: rtl/odd_lut_ctrl.sv
module odd_lut_ctrl
    import odd_lut_mult_pkg::*;
(
    input  logic [IN_W-1:0] x,
    output logic [SH_W-1:0] shamt,
    output logic            clear
);
    // shift amount = number of trailing zeros (3 when x is 0 or 8)
    always_comb begin
        casez (x)
            4'b???1: shamt = 2'd0;
            4'b??10: shamt = 2'd1;
            4'b?100: shamt = 2'd2;
            default: shamt = 2'd3;
        endcase
    end

    assign clear = ~|x;
endmodule

// File: rtl/odd_lut_encoder.sv
module odd_lut_encoder
    import odd_lut_mult_pkg::*;
(
    input  logic [IN_W-1:0]   x,
    input  logic [SH_W-1:0]   shamt,
    output logic [ADDR_W-1:0] addr
);
    logic [IN_W-1:0] odd_part;

    assign odd_part = x >> shamt;
    // address = (odd_part - 1) / 2
    assign addr     = odd_part[IN_W-1:1];
endmodule

// File: rtl/odd_lut_table.sv
module odd_lut_table
    import odd_lut_mult_pkg::*;
#(
    parameter int unsigned W    = 8,
    parameter int unsigned COEF = 181,
    localparam int unsigned PW  = W + IN_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [PW-1:0]     word
);
    logic [PW-1:0] rows [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_row
        assign rows[i] = PW'(COEF * (2 * i + 1));
    end

    assign word = rows[addr];
endmodule

// File: rtl/odd_lut_shifter.sv
module odd_lut_shifter
    import odd_lut_mult_pkg::*;
#(
    parameter int unsigned PW = 12
) (
    input  logic [PW-1:0]   din,
    input  logic [SH_W-1:0] shamt,
    input  logic            clear,
    output logic [PW-1:0]   dout
);
    logic [PW-1:0] stage [SH_W+1];

    assign stage[0] = din;

    for (genvar k = 0; k < SH_W; k++) begin : g_stage
        assign stage[k+1] = shamt[k] ? (stage[k] << (1 << k)) : stage[k];
    end

    // NOR row: bit survives only when clear is low
    for (genvar j = 0; j < PW; j++) begin : g_nor
        assign dout[j] = ~(~stage[SH_W][j] | clear);
    end
endmodule

// File: rtl/odd_lut_mult.sv
module odd_lut_mult
    import odd_lut_mult_pkg::*;
#(
    parameter int unsigned W    = 8,
    parameter int unsigned COEF = 181,
    localparam int unsigned PW  = W + IN_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [IN_W-1:0] x,
    output logic            out_valid,
    output logic [PW-1:0]   product
);
    logic [SH_W-1:0]   shamt;
    logic              clear;
    logic [ADDR_W-1:0] addr;
    logic [PW-1:0]     word;

    logic              v1_q;
    logic [PW-1:0]     word_q;
    logic [SH_W-1:0]   shamt_q;
    logic              clear_q;
    logic [PW-1:0]     shifted;

    odd_lut_ctrl u_ctrl (
        .x     (x),
        .shamt (shamt),
        .clear (clear)
    );

    odd_lut_encoder u_enc (
        .x     (x),
        .shamt (shamt),
        .addr  (addr)
    );

    odd_lut_table #(.W(W), .COEF(COEF)) u_table (
        .addr (addr),
        .word (word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v1_q    <= 1'b0;
            word_q  <= '0;
            shamt_q <= '0;
            clear_q <= 1'b1;
        end else begin
            v1_q <= in_valid;
            if (in_valid) begin
                word_q  <= word;
                shamt_q <= shamt;
                clear_q <= clear;
            end
        end
    end

    odd_lut_shifter #(.PW(PW)) u_shift (
        .din   (word_q),
        .shamt (shamt_q),
        .clear (clear_q),
        .dout  (shifted)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            product   <= '0;
        end else begin
            out_valid <= v1_q;
            if (v1_q) begin
                product <= shifted;
            end
        end
    end

    // R4: odd factor and shift rebuild the operand
    p_decomp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && x != '0) |-> ((IN_W'({addr, 1'b1}) << shamt) == x));

    // R2: output strobe follows the first stage by one edge
    p_valid_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(v1_q));

    // R3: a cleared stage yields zero
    p_zero_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (v1_q && clear_q) |=> (product == '0));

    // R5: product held when no result arrives
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !v1_q |=> $stable(product));

    // R8: nonzero coefficient and operand never give zero
    p_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (v1_q && !clear_q && COEF != 0) |=> (product != '0));
endmodule

// File: tb/odd_lut_mult_bench.sv
`timescale 1ns/1ps
module odd_lut_mult_bench;
    localparam int unsigned W  = 8;
    localparam int unsigned PW = W + 4;
    localparam int unsigned NC = 4;
    localparam int unsigned COEFS [NC] = '{0, 1, 181, (1 << W) - 1};

    typedef struct {
        logic [PW-1:0] exp [NC];
        int            due;
        logic [3:0]    xv;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [3:0] x = '0;
    logic            ov   [NC];
    logic [PW-1:0]   prod [NC];

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    item_t sb [$];
    logic [PW-1:0] last_exp [NC];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    for (genvar i = 0; i < NC; i++) begin : g_coef
        odd_lut_mult #(.W(W), .COEF(COEFS[i])) u_odd_lut_mult (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (in_valid),
            .x         (x),
            .out_valid (ov[i]),
            .product   (prod[i])
        );
    end

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // driver: one operand per call, pushes expected results
    task automatic drive(input logic [3:0] v);
        item_t it;
        @(negedge clk);
        in_valid = 1'b1;
        x = v;
        for (int i = 0; i < NC; i++) it.exp[i] = PW'(COEFS[i] * v);
        it.due = cyc + 2;
        it.xv = v;
        sb.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            x = 4'hA;
        end
    endtask

    // monitor: compares results at falling edges
    always @(negedge clk) begin
        if (rst_n) begin
            if (ov[0]) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R2 unexpected out_valid", 1, 0);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    check(cyc == it.due, "R2 latency", cyc, it.due);
                    for (int i = 0; i < NC; i++) begin
                        if (it.xv == 0)
                            check(prod[i] == 0, "R3 zero operand", prod[i], 0);
                        else if (COEFS[i] == 0)
                            check(prod[i] == 0, "R7 zero coefficient", prod[i], 0);
                        else if (COEFS[i] == (1 << W) - 1)
                            check(prod[i] == it.exp[i], "R7 max coefficient", prod[i], it.exp[i]);
                        else if (it.xv[0] == 1'b0)
                            check(prod[i] == it.exp[i], "R4 even operand", prod[i], it.exp[i]);
                        else
                            check(prod[i] == it.exp[i], "R1 product", prod[i], it.exp[i]);
                        if (it.xv != 0 && COEFS[i] != 0)
                            check(prod[i] != 0, "R8 nonzero", prod[i], it.exp[i]);
                        last_exp[i] = it.exp[i];
                    end
                end
            end else if (sb.size() != 0 && sb[0].due < cyc) begin
                check(1'b0, "R2 missing out_valid", cyc, sb[0].due);
                void'(sb.pop_front());
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", cyc, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R6: reset state
        for (int i = 0; i < NC; i++) begin
            check(ov[i] == 0, "R6 out_valid in reset", ov[i], 0);
            check(prod[i] == 0, "R6 product in reset", prod[i], 0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NC; i++) begin
            check(ov[i] == 0, "R6 out_valid after release", ov[i], 0);
            check(prod[i] == 0, "R6 product after release", prod[i], 0);
        end

        // R1: all operands back to back
        for (int v = 0; v < 16; v++) drive(4'(v));
        idle(4);

        // R4/R3: scrambled order with gaps
        drive(4'd15); drive(4'd0); drive(4'd8); idle(1);
        drive(4'd12); drive(4'd3); idle(2);
        drive(4'd0); drive(4'd0); drive(4'd6); drive(4'd9);
        drive(4'd4); idle(1); drive(4'd15); drive(4'd2);
        idle(4);

        // R5: product holds while idle
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            for (int i = 0; i < NC; i++)
                check(prod[i] == last_exp[i] && ov[i] == 0, "R5 hold", prod[i], last_exp[i]);
        end

        idle(2);
        check(sb.size() == 0, "R2 drained", sb.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule